// File: doc/BRIEF.md
# Flash Controller Interrupt Status Unit

This unit collects the event pulses of a flash memory controller and combines them into one interrupt line. Four controller events (FIFO underrun, FIFO overrun, command completion and ECC error) each set a sticky flag in an event status register. Software clears these flags by writing ones to them, so reading the register and writing the same value back acknowledges exactly the events that were seen. A configuration register holds one enable per event, a master interrupt enable and a four-bit error trigger value that is only stored and read back.

A second source, the DMA completion flag, is held in a separate DMA control word. It has its own enable bit and its own write-one-to-clear path. The interrupt line is high when the master enable is set and at least one enabled event flag is set. It is also high when the DMA completion flag and its enable are both set, whatever the master enable holds.

Register access uses a single-cycle write strobe with a two-bit address and a combinational read port with its own address. The interrupt output follows the registered state with no extra delay.

Top module: `ctl_irq_status`

## Requirements
- R1: After a synchronous reset, every flag and every enable is zero, all three registers read 0 and `irq` is low.
- R2: A pulse on `ev_underrun`, `ev_overrun`, `ev_cmd_done` or `ev_ecc_err` sets status bit 7, 6, 5 or 4 (address 0) at the next clock edge, and that bit stays set until software clears it.
- R3: A write to address 0 clears exactly those status bits 7..4 whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: If an event pulse and a clearing write reach the same flag in the same cycle, the flag is set after that edge. This applies to the status register and to the DMA completion flag.
- R5: Address 1 is the configuration register. Bits 7..4 enable the events that sit at the same positions in the status register, bit 0 is the master enable and bits 19..16 hold the trigger value. A write loads all of these fields, and every other bit reads 0.
- R6: Without the DMA path, `irq` is 1 exactly when the master enable is 1 and some status bit in 7..4 is set together with its enable.
- R7: Address 2 is the DMA control word. Bit 20 is the completion flag: a pulse on `ev_dma_done` sets it, and writing 1 to bit 20 clears it. Bit 28 is the completion interrupt enable and is loaded by every write to address 2.
- R8: When bits 20 and 28 of the DMA control word are both set, `irq` is 1, even with the master enable at 0.
- R9: Status bits other than 7..4 read 0 and cannot be set by writes. Address 3 reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_addr | input | 2 | Write register select (0 status, 1 configuration, 2 DMA control) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 32 | Combinational read data |
| ev_underrun | input | 1 | FIFO underrun event pulse |
| ev_overrun | input | 1 | FIFO overrun event pulse |
| ev_cmd_done | input | 1 | Command completion event pulse |
| ev_ecc_err | input | 1 | ECC error event pulse |
| ev_dma_done | input | 1 | DMA completion event pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
A flag that was lost, set by mistake or cleared at the wrong position shows up on `rd_data` in the cycle after the edge that caused it, because the read port is combinational. When that flag is enabled, the error also shows on `irq` in that same cycle. Same-cycle collisions between an event and a clear are driven on purpose, because a design where the clear wins would drop the event without any other sign. The DMA path is tested with the master enable off, so that the separate enable has to produce the interrupt on its own.

// File: rtl/ctl_irq_pkg.sv
package ctl_irq_pkg;

    localparam int N_EV         = 4;
    localparam int EV_LSB       = 4;
    localparam int BIT_GIE      = 0;
    localparam int TRIG_LSB     = 16;
    localparam int TRIG_W       = 4;
    localparam int BIT_DMA_DONE = 20;
    localparam int BIT_DMA_IE   = 28;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CFG    = 2'd1,
        SEL_DMACTL = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              gie;
        logic [N_EV-1:0]   ev_en;
        logic [TRIG_W-1:0] trig;
        logic              dma_ie;
    } irq_cfg_t;

    function automatic logic irq_eval(input irq_cfg_t cfg,
                                      input logic [N_EV-1:0] flags,
                                      input logic dma_done);
        logic ev_any;
        ev_any = |(flags & cfg.ev_en);
        return (cfg.gie & ev_any) | (cfg.dma_ie & dma_done);
    endfunction

endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (set_i[i])
                q <= 1'b1;
            else if (clr_i[i])
                q <= 1'b0;
        end

        assign q_o[i] = q;

        // R4
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> q_o[i]);

        // R2
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (q_o[i] && !clr_i[i]) |=> q_o[i]);

        // R3
        w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import ctl_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_cfg,
    input  logic              we_dma,
    input  logic [DATA_W-1:0] wdata,
    output irq_cfg_t          cfg_o
);

    irq_cfg_t cfg_q;
    logic     unused_wdata;

    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (we_cfg) begin
                cfg_q.gie   <= wdata[BIT_GIE];
                cfg_q.ev_en <= wdata[EV_LSB +: N_EV];
                cfg_q.trig  <= wdata[TRIG_LSB +: TRIG_W];
            end
            if (we_dma)
                cfg_q.dma_ie <= wdata[BIT_DMA_IE];
        end
    end

    assign cfg_o = cfg_q;

    // R5
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        we_cfg |=> (cfg_o.ev_en == $past(wdata[EV_LSB +: N_EV])));

    // R7
    dma_ie_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_dma |=> $stable(cfg_o.dma_ie));

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import ctl_irq_pkg::*;
(
    input  irq_cfg_t        cfg,
    input  logic [N_EV-1:0] flags,
    input  logic            dma_done,
    output logic            irq
);

    always_comb begin
        irq = irq_eval(cfg, flags, dma_done);
    end

endmodule

// File: rtl/ctl_irq_status.sv
module ctl_irq_status
    import ctl_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_underrun,
    input  logic              ev_overrun,
    input  logic              ev_cmd_done,
    input  logic              ev_ecc_err,
    input  logic              ev_dma_done,
    output logic              irq
);

    reg_sel_e        wsel, rsel;
    logic            we_status, we_cfg, we_dma;
    logic [N_EV-1:0] ev_vec, st_clr, st_q;
    logic [0:0]      dma_set, dma_clr, dma_q;
    irq_cfg_t        cfg;

    assign wsel      = reg_sel_e'(wr_addr[1:0]);
    assign rsel      = reg_sel_e'(rd_addr[1:0]);
    assign we_status = wr_en && (wsel == SEL_STATUS);
    assign we_cfg    = wr_en && (wsel == SEL_CFG);
    assign we_dma    = wr_en && (wsel == SEL_DMACTL);

    // Bank order follows status bit order: index 0 is bit EV_LSB.
    assign ev_vec  = {ev_underrun, ev_overrun, ev_cmd_done, ev_ecc_err};
    assign st_clr  = we_status ? wr_data[EV_LSB +: N_EV] : '0;
    assign dma_set = ev_dma_done;
    assign dma_clr = we_dma ? wr_data[BIT_DMA_DONE] : 1'b0;

    irq_w1c_bank #(.W(N_EV)) u_status (
        .clk   (clk),
        .rst   (rst),
        .set_i (ev_vec),
        .clr_i (st_clr),
        .q_o   (st_q)
    );

    irq_w1c_bank #(.W(1)) u_dma_done (
        .clk   (clk),
        .rst   (rst),
        .set_i (dma_set),
        .clr_i (dma_clr),
        .q_o   (dma_q)
    );

    irq_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we_cfg (we_cfg),
        .we_dma (we_dma),
        .wdata  (wr_data),
        .cfg_o  (cfg)
    );

    irq_combiner u_comb (
        .cfg      (cfg),
        .flags    (st_q),
        .dma_done (dma_q[0]),
        .irq      (irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_STATUS: rd_data[EV_LSB +: N_EV] = st_q;
            SEL_CFG: begin
                rd_data[BIT_GIE]             = cfg.gie;
                rd_data[EV_LSB +: N_EV]      = cfg.ev_en;
                rd_data[TRIG_LSB +: TRIG_W]  = cfg.trig;
            end
            SEL_DMACTL: begin
                rd_data[BIT_DMA_DONE] = dma_q[0];
                rd_data[BIT_DMA_IE]   = cfg.dma_ie;
            end
            default: rd_data = '0;
        endcase
    end

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.gie && !(cfg.dma_ie && dma_q[0])) |-> !irq);

    // R8
    dma_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.dma_ie && dma_q[0]) |-> irq);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (st_q == '0 && dma_q == '0 && !irq));

endmodule

// File: tb/sim_ctl_irq_status.sv
module sim_ctl_irq_status;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ev_underrun = 1'b0, ev_overrun = 1'b0, ev_cmd_done = 1'b0;
    logic        ev_ecc_err = 1'b0, ev_dma_done = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    ctl_irq_status u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_underrun(ev_underrun), .ev_overrun(ev_overrun),
        .ev_cmd_done(ev_cmd_done), .ev_ecc_err(ev_ecc_err),
        .ev_dma_done(ev_dma_done), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    // One clock: optional write plus event vector {dma, und, ovr, cmd, ecc}.
    task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d,
                       input logic [4:0] ev);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        {ev_dma_done, ev_underrun, ev_overrun, ev_cmd_done, ev_ecc_err} = ev;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        {ev_dma_done, ev_underrun, ev_overrun, ev_cmd_done, ev_ecc_err} = '0;
    endtask

    task automatic t_reset;
        check_reg("R1 status", 2'd0, 32'h0);
        check_reg("R1 cfg", 2'd1, 32'h0);
        check_reg("R1 dmactl", 2'd2, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_sticky;
        cyc(1'b0, 2'd0, 32'h0, 5'b00100);
        check_reg("R2 overrun set", 2'd0, 32'h40);
        cyc(1'b0, 2'd0, 32'h0, 5'b00000);
        cyc(1'b0, 2'd0, 32'h0, 5'b00000);
        check_reg("R2 overrun held", 2'd0, 32'h40);
        check("R6 irq off without enables", {31'b0, irq}, 32'h0);
        cyc(1'b1, 2'd0, 32'h40, 5'b00000);
    endtask

    task automatic t_w1c;
        cyc(1'b0, 2'd0, 32'h0, 5'b01111);
        check_reg("R2 all four set", 2'd0, 32'hF0);
        cyc(1'b1, 2'd0, 32'h50, 5'b00000);
        check_reg("R3 partial clear", 2'd0, 32'hA0);
        cyc(1'b1, 2'd0, 32'h0, 5'b00000);
        check_reg("R3 zero write keeps", 2'd0, 32'hA0);
        cyc(1'b1, 2'd0, 32'hFFFF_FF0F, 5'b00000);
        check_reg("R9 outside bits inert", 2'd0, 32'hA0);
        cyc(1'b1, 2'd3, 32'hFFFF_FFFF, 5'b00000);
        check_reg("R9 addr3 write inert", 2'd0, 32'hA0);
        check_reg("R9 addr3 reads zero", 2'd3, 32'h0);
        cyc(1'b1, 2'd0, 32'hA0, 5'b00000);
        check_reg("R3 full clear", 2'd0, 32'h0);
    endtask

    task automatic t_collide;
        cyc(1'b0, 2'd0, 32'h0, 5'b00010);
        cyc(1'b1, 2'd0, 32'h20, 5'b00010);
        check_reg("R4 event wins over clear", 2'd0, 32'h20);
        cyc(1'b1, 2'd0, 32'h20, 5'b00000);
        check_reg("R4 later clear", 2'd0, 32'h0);
    endtask

    task automatic t_enable;
        cyc(1'b1, 2'd1, 32'hFFFF_FFFF, 5'b00000);
        check_reg("R5 cfg fields", 2'd1, 32'h000F_00F1);
        cyc(1'b1, 2'd1, 32'h0003_0010, 5'b00000);
        check_reg("R5 cfg reload", 2'd1, 32'h0003_0010);
        cyc(1'b1, 2'd1, 32'h0, 5'b00000);
    endtask

    task automatic t_irq;
        cyc(1'b1, 2'd1, 32'h21, 5'b00000);
        cyc(1'b0, 2'd0, 32'h0, 5'b00001);
        check("R6 disabled event no irq", {31'b0, irq}, 32'h0);
        cyc(1'b0, 2'd0, 32'h0, 5'b00010);
        check("R6 enabled event irq", {31'b0, irq}, 32'h1);
        cyc(1'b1, 2'd1, 32'h20, 5'b00000);
        check("R6 master off", {31'b0, irq}, 32'h0);
        cyc(1'b1, 2'd1, 32'h21, 5'b00000);
        check("R6 master back on", {31'b0, irq}, 32'h1);
        cyc(1'b1, 2'd0, 32'h30, 5'b00000);
        check("R6 cleared no irq", {31'b0, irq}, 32'h0);
        cyc(1'b1, 2'd1, 32'h0, 5'b00000);
    endtask

    task automatic t_dma;
        cyc(1'b0, 2'd0, 32'h0, 5'b10000);
        check_reg("R7 done flag set", 2'd2, 32'h0010_0000);
        check("R8 no irq without enable", {31'b0, irq}, 32'h0);
        cyc(1'b1, 2'd2, 32'h1000_0000, 5'b00000);
        check_reg("R7 enable loaded flag kept", 2'd2, 32'h1010_0000);
        check("R8 dma irq master off", {31'b0, irq}, 32'h1);
        cyc(1'b1, 2'd2, 32'h1010_0000, 5'b00000);
        check_reg("R7 done cleared", 2'd2, 32'h1000_0000);
        check("R8 irq drops", {31'b0, irq}, 32'h0);
        cyc(1'b0, 2'd0, 32'h0, 5'b10000);
        cyc(1'b1, 2'd2, 32'h1010_0000, 5'b10000);
        check_reg("R4 dma event wins", 2'd2, 32'h1010_0000);
        check_reg("R9 status untouched by dma", 2'd0, 32'h0);
    endtask

    task automatic t_reset_again;
        cyc(1'b1, 2'd1, 32'h000F_00F1, 5'b01111);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sticky();
        t_w1c();
        t_collide();
        t_enable();
        t_irq();
        t_dma();
        t_reset_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule